// File: doc/BRIEF.md
# Banked Peripheral Clock Gate Registers

This block holds the clock-enable state for up to 64 peripherals and turns each enable into a glitch-free gated clock. Software never writes the enable state directly. It writes a mask of ones to a set register to switch clocks on, or to a clear register to switch them off, and reads the result back from a status register. The peripherals are split into banks of 32. Each bank has its own set, clear and status registers.

The two lowest peripheral numbers have no gate. Their clocks always run and their status always reads as enabled. Every other clock is off after reset. Each gated clock passes through a latch that is transparent only while the source clock is low. A change of enable therefore never cuts or stretches a high phase that is already in progress.

Top module: `pclk_gate_regs`

## Requirements
- R1: While reset is asserted, and after it is released, every gateable enable is 0. Reading bank 0 status returns 0x00000003 and reading bank 1 status returns 0x00000000.
- R2: The address is {bank, op}, with op in addr[1:0]. A write with op 0 (set) turns on every peripheral whose bit in wdata is 1. Peripherals whose bit is 0 keep their state.
- R3: A write with op 1 (clear) turns off every peripheral whose bit in wdata is 1. Peripherals whose bit is 0 keep their state.
- R4: Peripherals 0 and 1 cannot be gated. Set and clear writes do not change them. Their clk_en bits and their status bits always read 1, and their gclk follows clk.
- R5: Peripheral n belongs to bank n/32 at bit n mod 32. Its state appears on clk_en[n] and gclk[n].
- R6: A read with rd_en high and op 2 (status) returns the addressed bank's enable state on rd_data one clock later. A read with op 3 returns 0.
- R7: An enable that changes at a clock edge does not affect gclk during the high phase that follows that edge. It takes effect from the next high phase onward. gclk is low whenever clk is low.
- R8: Writes with op 2 or op 3 do not change any enable.
- R9: When we is low, the enables do not change, whatever the values of addr and wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears one cycle later |
| addr | input | 3 | {bank, op}: op 0 set, 1 clear, 2 status, 3 reserved |
| wdata | input | 32 | Write mask |
| rd_data | output | 32 | Registered read data |
| clk_en | output | 64 | Per-peripheral clock enable |
| gclk | output | 64 | Per-peripheral gated clock |

## Verification
The assertions check four things on every clock edge:
- A set write leaves all of its masked bits on.
- A clear write leaves all of its masked bits off, except in the ungated positions.
- No other bus activity moves the enables.
- Status reads return the state from the previous cycle, and the two ungated bits always read back as 1.

Some behaviour only the bench scenarios can show. One case is the mapping of a peripheral number to its bank and bit. Another is that masked-off bits survive across a chain of writes. The last is the phase behaviour of the gated clock: no pulse in the high phase right after an enable rises, and one full pulse after an enable falls.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;
  localparam int BANK_W = 32;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_CLR  = 2'd1,
    OP_STAT = 2'd2,
    OP_RSVD = 2'd3
  } reg_op_e;

  // Next enable state: clear beats set, ungated bits are forced on.
  function automatic logic [BANK_W-1:0] apply_write(
    input logic [BANK_W-1:0] cur,
    input logic [BANK_W-1:0] set_m,
    input logic [BANK_W-1:0] clr_m,
    input logic [BANK_W-1:0] fixed_m);
    return ((cur | set_m) & ~clr_m) | fixed_m;
  endfunction

  // Bits of a bank whose peripheral number is below the ungated count.
  function automatic logic [BANK_W-1:0] fixed_bits(input int bank, input int n_ungated);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++)
      if (bank * BANK_W + i < n_ungated) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pclk_decode.sv
`timescale 1ns/1ps
module pclk_decode
  import pclk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 3
) (
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BANK_W-1:0]                 wdata,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  set_mask,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  clr_mask
);
  localparam int SEL_W = ADDR_W - 2;

  reg_op_e          op;
  logic [SEL_W-1:0] sel;
  assign op  = reg_op_e'(addr[1:0]);
  assign sel = addr[ADDR_W-1:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    logic hit;
    assign hit         = we && (sel == SEL_W'(b));
    assign set_mask[b] = (hit && op == OP_SET) ? wdata : '0;
    assign clr_mask[b] = (hit && op == OP_CLR) ? wdata : '0;
  end
endmodule

// File: rtl/pclk_bank.sv
`timescale 1ns/1ps
module pclk_bank
  import pclk_pkg::*;
#(
  parameter logic [BANK_W-1:0] FIXED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] set_mask,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [BANK_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= FIXED;
    else        state <= apply_write(state, set_mask, clr_mask, FIXED);
  end
endmodule

// File: rtl/pclk_gate_cell.sv
`timescale 1ns/1ps
module pclk_gate_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;
  // Transparent only while the source clock is low.
  always_latch begin
    if (!clk) en_lat = en;
  end
  assign gclk = clk & en_lat;
endmodule

// File: rtl/pclk_gate_regs.sv
`timescale 1ns/1ps
module pclk_gate_regs
  import pclk_pkg::*;
#(
  parameter int NUM_PERIPH  = 64,
  parameter int NUM_UNGATED = 2,
  parameter int NUM_BANKS   = NUM_PERIPH / BANK_W,
  parameter int ADDR_W      = 2 + $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_W-1:0]     wdata,
  output logic [BANK_W-1:0]     rd_data,
  output logic [NUM_PERIPH-1:0] clk_en,
  output logic [NUM_PERIPH-1:0] gclk
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] set_mask;
  logic [NUM_BANKS-1:0][BANK_W-1:0] clr_mask;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_state;
  logic [BANK_W-1:0]                rd_word;
  reg_op_e                          rd_op;

  pclk_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .we(we), .addr(addr), .wdata(wdata),
    .set_mask(set_mask), .clr_mask(clr_mask));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pclk_bank #(.FIXED(fixed_bits(b, NUM_UNGATED))) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_mask(set_mask[b]), .clr_mask(clr_mask[b]),
      .state(bank_state[b]));
    assign clk_en[b*BANK_W +: BANK_W] = bank_state[b];
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_clk
    if (i < NUM_UNGATED) begin : g_free
      assign gclk[i] = clk;
    end else begin : g_gated
      pclk_gate_cell u_gate (.clk(clk), .en(clk_en[i]), .gclk(gclk[i]));
    end
  end

  assign rd_op   = reg_op_e'(addr[1:0]);
  assign rd_word = (rd_op == OP_STAT) ? bank_state[addr[ADDR_W-1:2]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/pclk_gate_regs_chk.sv
`timescale 1ns/1ps
module pclk_gate_regs_chk
  import pclk_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  we,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [BANK_W-1:0]     wdata,
  input logic [BANK_W-1:0]     rd_data,
  input logic [NUM_PERIPH-1:0] clk_en
);
  logic mod_wr;
  assign mod_wr = we && (addr[1:0] == OP_SET || addr[1:0] == OP_CLR);

  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> clk_en[NUM_PERIPH-1:2] == '0);

  assert_ungated_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == {{(ADDR_W-2){1'b0}}, OP_STAT}) |=> rd_data[1:0] == 2'b11);

  assert_reserved_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] == OP_RSVD) |=> rd_data == '0);

  assert_other_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr[1:0] == OP_STAT || addr[1:0] == OP_RSVD)) |=> $stable(clk_en));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_wr |=> $stable(clk_en));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    localparam logic [ADDR_W-1:0] A_SET  = {(ADDR_W-2)'(b), OP_SET};
    localparam logic [ADDR_W-1:0] A_CLR  = {(ADDR_W-2)'(b), OP_CLR};
    localparam logic [ADDR_W-1:0] A_STAT = {(ADDR_W-2)'(b), OP_STAT};
    localparam logic [BANK_W-1:0] KEEP   = fixed_bits(b, 2);

    assert_set_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_SET) |=>
        (clk_en[b*BANK_W +: BANK_W] & $past(wdata)) == $past(wdata));

    assert_clr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_CLR) |=>
        (clk_en[b*BANK_W +: BANK_W] & $past(wdata) & ~KEEP) == '0);

    assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_STAT) |=> rd_data == $past(clk_en[b*BANK_W +: BANK_W]));
  end
endmodule

bind pclk_gate_regs pclk_gate_regs_chk #(
  .NUM_PERIPH(NUM_PERIPH), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .clk_en(clk_en));

// File: tb/pclk_gate_regs_bench.sv
`timescale 1ns/1ps
module pclk_gate_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [63:0] clk_en;
  logic [63:0] gclk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] model = 64'h3;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pclk_gate_regs u_pclk_gate_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .clk_en(clk_en), .gclk(gclk));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Driver: one bus write; model updated after the committing edge.
  task automatic do_write(int bank, int op, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = {bank[0], op[1:0]}; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (op == 0) model[bank*32 +: 32] = model[bank*32 +: 32] | d;
    if (op == 1) model[bank*32 +: 32] = model[bank*32 +: 32] & ~d;
    model[1:0] = 2'b11;
  endtask

  // Driver: one bus read; expected word pushed to the scoreboard.
  task automatic do_read(int bank, int op, string tag);
    item_t it;
    it.exp = (op == 2) ? model[bank*32 +: 32] : 32'h0;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b1; addr = {bank[0], op[1:0]};
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: rd_en captured at an edge gives rd_data just after it.
  always @(posedge clk) begin
    logic seen;
    item_t it;
    seen = rd_en;
    #1;
    if (seen) begin
      if (sb_q.size() == 0) chk("scoreboard underflow", 64'd1, 64'd0);
      else begin
        it = sb_q.pop_front();
        chk(it.tag, {32'h0, rd_data}, {32'h0, it.exp});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 clk_en in reset", clk_en, 64'h3);
    @(negedge clk); rst_n = 1'b1;
    do_read(0, 2, "R1 bank0 status after reset");
    do_read(1, 2, "R1 bank1 status after reset");
    chk("R1 clk_en after reset", clk_en, 64'h3);

    do_write(0, 0, 32'hF0F0_000C);
    chk("R2 set bank0", clk_en, model);
    do_read(0, 2, "R2 bank0 status after set");
    do_write(0, 0, 32'h0000_0100);
    chk("R2 zero bits keep others", clk_en, model);

    do_write(1, 0, 32'h8000_0021);
    chk("R5 id37 on", {63'h0, clk_en[37]}, 64'h1);
    chk("R5 id63 on", {63'h0, clk_en[63]}, 64'h1);
    chk("R5 id5 untouched", {63'h0, clk_en[5]}, 64'h0);
    do_read(1, 2, "R5 bank1 status");

    do_write(1, 1, 32'h0000_0001);
    chk("R3 clear id32 keep others", clk_en, model);
    do_read(1, 2, "R3 bank1 status after clear");
    do_write(0, 1, 32'hFFFF_FFFF);
    chk("R3 clear all bank0", clk_en, model);
    do_read(0, 2, "R4 ungated bits still read 1");
    chk("R4 clk_en[1:0]", {62'h0, clk_en[1:0]}, 64'h3);

    do_write(0, 2, 32'hFFFF_FFFF);
    chk("R8 write to status", clk_en, model);
    do_write(1, 3, 32'hFFFF_FFFF);
    chk("R8 write to reserved", clk_en, model);
    do_read(1, 3, "R6 reserved read is 0");

    @(negedge clk); addr = 3'b000; wdata = 32'hFFFF_FFFF;
    @(negedge clk); addr = 3'b101;
    @(negedge clk);
    chk("R9 no strobe no change", clk_en, model);

    // Gate timing on peripheral 40 (bank1 bit 8).
    @(negedge clk); we = 1'b1; addr = 3'b100; wdata = 32'h100;
    @(posedge clk); #1;
    chk("R7 enable on, clk_en[40]", {63'h0, clk_en[40]}, 64'h1);
    chk("R7 no pulse in commit high phase", {63'h0, gclk[40]}, 64'h0);
    chk("R4 gclk[0] follows clk high", {63'h0, gclk[0]}, 64'h1);
    @(negedge clk); we = 1'b0; model[40] = 1'b1; #1;
    chk("R7 gclk low with clk low", {63'h0, gclk[40]}, 64'h0);
    @(posedge clk); #1;
    chk("R7 pulse from next high phase", {63'h0, gclk[40]}, 64'h1);
    @(negedge clk); we = 1'b1; addr = 3'b101; wdata = 32'h100;
    @(posedge clk); #1;
    chk("R7 disable keeps current high phase", {63'h0, gclk[40]}, 64'h1);
    @(negedge clk); we = 1'b0; model[40] = 1'b0;
    @(posedge clk); #1;
    chk("R7 gated off next high phase", {63'h0, gclk[40]}, 64'h0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule